// File: doc/BRIEF.md
# Power-Up Reset Delay Sequencer

This block keeps the rest of the device in reset after power is applied, until the supply has had time to settle and the selected oscillator is running cleanly. A power-on reset pulse starts the sequence. The block then runs up to three waits in a fixed order. The first is a fixed power-up wait, timed on an always-on reference clock. The second counts rising edges of the raw oscillator, and runs only when a crystal is selected. The third is a wait for the PLL to lock, and runs only when the PLL crystal mode is selected. The internal reset output drops only when the last wait that applies has finished.

Everything runs on the reference clock. The raw oscillator input is passed through a synchronizer and an edge detector, and only its rising edges are counted, so the oscillator must run slower than half the reference rate. A `stage` output reports which wait is active.

Top module: `pwrup_seq`

## Requirements
- R1: While `por` is high, and in the first cycle after it falls, `stage` is 0 (power-up wait) and `rst_hold` is 1. Stage codes are: 0 power-up wait, 1 oscillator start-up count, 2 PLL wait, 3 released.
- R2: With `pwrt_en` = 1, stage 0 lasts exactly `PWRT_CYC` reference cycles after `por` falls.
- R3: With `pwrt_en` = 0, stage 0 lasts exactly one reference cycle.
- R4: `osc_mode` codes 0 (low-power crystal), 1 (standard crystal), 2 (high-speed crystal) and 3 (high-speed crystal with PLL) go from stage 0 to stage 1. Codes 4 to 7 (external clock and RC types) go from stage 0 straight to stage 3.
- R5: Stage 1 ends in the cycle after the `OST_EDGES`-th synchronized rising edge of `osc_in` seen during that stage. If `osc_in` never toggles, stage 1 never ends.
- R6: Mode 3 goes from stage 1 to stage 2, and stage 2 lasts exactly `PLL_CYC` reference cycles. Modes 0 to 2 go from stage 1 straight to stage 3.
- R7: `stage` never decreases except through `por`. Stage 3 holds until the next `por`. `rst_hold` is 1 exactly when `stage` is not 3.
- R8: A `por` pulse at any point returns the block to stage 0, and the full sequence then restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Always-on reference clock |
| por | input | 1 | Power-on reset pulse, active high, asynchronous |
| pwrt_en | input | 1 | Configuration enable for the power-up wait |
| osc_mode | input | 3 | Oscillator mode code |
| osc_in | input | 1 | Raw oscillator clock, sampled |
| rst_hold | output | 1 | Internal reset held to the device, active high |
| stage | output | 2 | Current stage code |

## Verification
Two events can land on the same reference edge: a synchronized oscillator edge at the moment stage 1 is entered, and the counter's terminal count together with the stage change. The bench sweeps all eight modes with the power-up wait both enabled and disabled. It drives `osc_in` at a period that is not aligned with the stage boundaries, so edges fall close to the entry into stage 1. Each run is judged by the cycle index at which each stage ends. The number of oscillator edges seen during stage 1 must stay within one of `OST_EDGES`.

// File: rtl/pus_pkg.sv
package pus_pkg;

  typedef enum logic [1:0] {
    ST_PWRT = 2'd0,
    ST_OST  = 2'd1,
    ST_PLL  = 2'd2,
    ST_DONE = 2'd3
  } stage_t;

  localparam logic [2:0] MODE_PLL = 3'd3;

  // Crystal modes occupy codes 0..3; the PLL mode is one of them.
  function automatic logic mode_is_crystal(input logic [2:0] mode);
    return mode[2] == 1'b0;
  endfunction

  function automatic logic mode_is_pll(input logic [2:0] mode);
    return mode == MODE_PLL;
  endfunction

  // Next required stage after the current one, skipping unused stages.
  function automatic stage_t stage_after(input stage_t cur, input logic [2:0] mode);
    stage_t nx;
    case (cur)
      ST_PWRT: nx = mode_is_crystal(mode) ? ST_OST : ST_DONE;
      ST_OST:  nx = mode_is_pll(mode) ? ST_PLL : ST_DONE;
      default: nx = ST_DONE;
    endcase
    return nx;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b,
                                            input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/pus_edge_sync.sv
module pus_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic rise
);
  localparam int unsigned W = SYNC_STAGES + 1;
  logic [W-1:0] sh;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sh <= '0;
    else     sh <= {sh[W-2:0], d_async};
  end

  assign rise = sh[W-2] & ~sh[W-1];
endmodule

// File: rtl/pus_stage_ctl.sv
module pus_stage_ctl
  import pus_pkg::*;
#(
  parameter int unsigned PWRT_CYC  = 2048,
  parameter int unsigned OST_EDGES = 1024,
  parameter int unsigned PLL_CYC   = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwrt_en,
  input  logic [2:0] osc_mode,
  input  logic       osc_rise,
  output stage_t     stage_q,
  output logic       advance
);
  localparam int unsigned CW = cnt_width(PWRT_CYC, OST_EDGES, PLL_CYC);
  localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_CYC - 1);
  localparam logic [CW-1:0] OST_LAST  = CW'(OST_EDGES - 1);
  localparam logic [CW-1:0] PLL_LAST  = CW'(PLL_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  always_comb begin
    advance = 1'b0;
    tick    = 1'b0;
    case (stage_q)
      ST_PWRT: begin
        tick    = 1'b1;
        advance = !pwrt_en || (cnt_q == PWRT_LAST);
      end
      ST_OST: begin
        tick    = osc_rise;
        advance = osc_rise && (cnt_q == OST_LAST);
      end
      ST_PLL: begin
        tick    = 1'b1;
        advance = (cnt_q == PLL_LAST);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage_q <= ST_PWRT;
      cnt_q   <= '0;
    end else if (advance) begin
      stage_q <= stage_after(stage_q, osc_mode);
      cnt_q   <= '0;
    end else if (tick) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq #(
  parameter int unsigned PWRT_CYC  = 2048,
  parameter int unsigned OST_EDGES = 1024,
  parameter int unsigned PLL_CYC   = 2000
) (
  input  logic       clk_ref,
  input  logic       por,
  input  logic       pwrt_en,
  input  logic [2:0] osc_mode,
  input  logic       osc_in,
  output logic       rst_hold,
  output logic [1:0] stage
);
  import pus_pkg::*;

  logic   osc_edge;
  logic   stage_adv;
  stage_t stage_q;

  pus_edge_sync #(.SYNC_STAGES(2)) u_sync (
    .clk     (clk_ref),
    .rst     (por),
    .d_async (osc_in),
    .rise    (osc_edge)
  );

  pus_stage_ctl #(
    .PWRT_CYC  (PWRT_CYC),
    .OST_EDGES (OST_EDGES),
    .PLL_CYC   (PLL_CYC)
  ) u_ctl (
    .clk      (clk_ref),
    .rst      (por),
    .pwrt_en  (pwrt_en),
    .osc_mode (osc_mode),
    .osc_rise (osc_edge),
    .stage_q  (stage_q),
    .advance  (stage_adv)
  );

  assign stage    = stage_q;
  assign rst_hold = (stage_q != ST_DONE);
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk (
  input logic       clk_ref,
  input logic       por,
  input logic       pwrt_en,
  input logic [2:0] osc_mode,
  input logic       rst_hold,
  input logic [1:0] stage,
  input logic       osc_edge
);
  a_r7_no_backstep: assert property (@(posedge clk_ref) disable iff (por)
    stage >= $past(stage))
    else $error("stage moved backwards");

  a_r7_done_sticky: assert property (@(posedge clk_ref) disable iff (por)
    stage == 2'd3 |=> stage == 2'd3)
    else $error("released stage left");

  a_r7_release_point: assert property (@(posedge clk_ref) disable iff (por)
    $fell(rst_hold) |-> stage == 2'd3)
    else $error("reset released outside stage 3");

  a_r3_skip_pwrt: assert property (@(posedge clk_ref) disable iff (por)
    (stage == 2'd0 && !pwrt_en) |=> stage != 2'd0)
    else $error("disabled power-up wait not skipped");

  a_r4_ost_crystal_only: assert property (@(posedge clk_ref) disable iff (por)
    stage == 2'd1 |-> !osc_mode[2])
    else $error("start-up count in non-crystal mode");

  a_r6_pll_mode_only: assert property (@(posedge clk_ref) disable iff (por)
    stage == 2'd2 |-> osc_mode == 3'd3)
    else $error("PLL wait outside PLL mode");

  a_r5_ost_needs_edge: assert property (@(posedge clk_ref) disable iff (por)
    (stage == 2'd1 && !osc_edge) |=> stage == 2'd1)
    else $error("start-up count ended without an edge");
endmodule

bind pwrup_seq pwrup_seq_chk u_chk (
  .clk_ref  (clk_ref),
  .por      (por),
  .pwrt_en  (pwrt_en),
  .osc_mode (osc_mode),
  .rst_hold (rst_hold),
  .stage    (stage),
  .osc_edge (osc_edge)
);

// File: tb/tb_pwrup_seq.sv
module tb_pwrup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int P = 12;
  localparam int N = 6;
  localparam int L = 20;
  localparam int H = 3;

  logic clk_ref = 0;
  logic por = 1;
  logic pwrt_en = 1;
  logic [2:0] osc_mode = 0;
  logic osc_in = 0;
  logic rst_hold;
  logic [1:0] stage;

  int checks = 0;
  int errors = 0;

  pwrup_seq #(.PWRT_CYC(P), .OST_EDGES(N), .PLL_CYC(L)) dut (
    .clk_ref(clk_ref), .por(por), .pwrt_en(pwrt_en), .osc_mode(osc_mode),
    .osc_in(osc_in), .rst_hold(rst_hold), .stage(stage)
  );

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_por();
    por = 1;
    osc_in = 0;
    repeat (2) @(negedge clk_ref);
    chk(stage == 2'd0 && rst_hold, "R1 during por", {stage, rst_hold}, 1);
    por = 0;
    #1;
    chk(stage == 2'd0 && rst_hold, "R1 after por", {stage, rst_hold}, 1);
  endtask

  // Runs one sequence from por release; records the index of each stage change.
  task automatic run_cfg(input int mode, input bit en);
    int enter[4];
    int prev, rises, after_pwrt, after_ost, done_k;
    bit hold_ok, mono_ok, xtal, pll;
    osc_mode = 3'(mode);
    pwrt_en = en;
    apply_por();
    enter = '{-1, -1, -1, -1};
    prev = 0; rises = 0; after_pwrt = -1; after_ost = -1; done_k = -1;
    hold_ok = 1; mono_ok = 1;
    for (int k = 1; k < 1500; k++) begin
      @(negedge clk_ref);
      if (rst_hold != (stage != 2'd3)) hold_ok = 0;
      if (int'(stage) < prev) mono_ok = 0;
      if (int'(stage) != prev) begin
        enter[stage] = k;
        if (prev == 0) after_pwrt = stage;
        if (prev == 1) after_ost = stage;
        if (stage == 2'd3) done_k = k;
      end
      if (stage == 2'd1 && (k % (2*H)) == H) rises++;
      osc_in = ((k / H) % 2) == 1;
      prev = stage;
      if (done_k > 0 && k > done_k + 5) break;
    end
    xtal = (mode < 4);
    pll  = (mode == 3);
    if (en) chk(enter[after_pwrt < 0 ? 3 : after_pwrt] == P, "R2 pwrt length",
                enter[after_pwrt < 0 ? 3 : after_pwrt], P);
    else    chk(enter[after_pwrt < 0 ? 3 : after_pwrt] == 1, "R3 pwrt skipped",
                enter[after_pwrt < 0 ? 3 : after_pwrt], 1);
    chk(after_pwrt == (xtal ? 1 : 3), "R4 stage after pwrt", after_pwrt, xtal ? 1 : 3);
    if (xtal) begin
      chk(rises >= N-1 && rises <= N+1, "R5 osc edges in ost", rises, N);
      chk(after_ost == (pll ? 2 : 3), "R6 stage after ost", after_ost, pll ? 2 : 3);
    end
    if (pll) chk(enter[3] - enter[2] == L, "R6 pll wait length", enter[3] - enter[2], L);
    chk(hold_ok && mono_ok && stage == 2'd3 && !rst_hold, "R7 order and hold",
        {hold_ok, mono_ok, rst_hold}, 6);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int m = 0; m < 8; m++)
      for (int e = 0; e < 2; e++)
        run_cfg(m, e[0]);

    // R5: oscillator stopped, stage 1 must never end
    osc_mode = 3'd1; pwrt_en = 0;
    apply_por();
    repeat (300) @(negedge clk_ref);
    chk(stage == 2'd1 && rst_hold, "R5 stalled without osc", stage, 1);

    // R8: por mid-sequence restarts from stage 0
    osc_mode = 3'd3; pwrt_en = 1;
    apply_por();
    repeat (P + 5) @(negedge clk_ref);
    chk(stage == 2'd1, "R8 reached ost before restart", stage, 1);
    por = 1;
    @(negedge clk_ref);
    chk(stage == 2'd0 && rst_hold, "R8 restart to stage 0", stage, 0);
    por = 0;
    #1;
    for (int k = 1; k <= P; k++) begin
      @(negedge clk_ref);
      if (k == P - 1) chk(stage == 2'd0, "R8 full pwrt after restart", stage, 0);
      if (k == P)     chk(stage == 2'd1, "R8 ost after restart", stage, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule